// File: doc/BRIEF.md
# Page Access Permission Gate

This block sits after a page table walk and judges one memory access against the 64-bit translation entry the walk returned. The caller supplies the entry, the kind of access (data read, data write or instruction fetch), whether the access comes from user mode, and the 12-bit offset inside the page. One cycle later the block reports whether the access is allowed. If it is not, the block gives a fault and a cause code. If it is, the block gives the physical byte address and the entry with its usage flags brought up to date.

When an allowed access leaves the usage flags as they were, nothing needs to go back to memory. A write-back strobe rises only when the updated entry actually differs from the entry that came in, so the table is not rewritten for accesses that change nothing. The two cache-policy bits of the entry are copied to dedicated outputs and are not interpreted here.

Top module: `pte_access_gate`

## Requirements
- R1: A synchronous active-high reset drives every output to zero, even while a request is being presented.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high and is low otherwise; response fields load only on a request.
- R3: If entry bit 0 (present) is 0, the access faults with cause 1, whatever the other bits, the mode or the access kind.
- R4: If the entry is present, the request is in user mode (`req_user`=1) and entry bit 2 (user-accessible) is 0, the access faults with cause 2.
- R5: If R3 and R4 do not apply, a write (`req_kind`=1) to an entry whose bit 1 (writable) is 0 faults with cause 3. This check applies in both modes.
- R6: If R3 to R5 do not apply, an instruction fetch (`req_kind`=2) from an entry whose bit 63 (no-execute) is 1 faults with cause 4. Kind 0 and the spare kind 3 are data reads.
- R7: A faulting response has `rsp_fault`=1, `rsp_entry` equal to the input entry, and `rsp_wb`=0. An allowed response has `rsp_fault`=0 and cause 0.
- R8: An allowed access of any kind sets entry bit 5 (accessed). Only an allowed write sets entry bit 6 (dirty). Flags that are already set stay set.
- R9: On an allowed response, `rsp_wb` is 1 exactly when `rsp_entry` differs from the input entry.
- R10: `rsp_paddr` is entry bits 51:12 placed above the 12-bit `req_offset`, giving a 52-bit byte address.
- R11: Entry bits 3 (write-through) and 4 (cache disable) appear on `rsp_wt` and `rsp_nocache`. All entry bits other than 5 and 6, including bits 9-11 and 52-62, pass to `rsp_entry` unchanged and do not affect the checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_entry | input | 64 | Translation entry to check |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 = user-mode access |
| req_offset | input | 12 | Byte offset within the page |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 3 | 0 none, 1 absent, 2 privilege, 3 read-only, 4 no-execute |
| rsp_entry | output | 64 | Updated entry (or the input entry on a fault) |
| rsp_wb | output | 1 | Entry changed and must be written back |
| rsp_paddr | output | 52 | Physical byte address |
| rsp_wt | output | 1 | Copy of the write-through bit |
| rsp_nocache | output | 1 | Copy of the cache-disable bit |

## Verification
The bench sweeps every combination of present, writable, user, accessed, dirty and no-execute, with all four access kinds and both modes, and fills the other entry bits with pseudo-random data. Entries that break several checks at once expose a wrong priority order: such a design would report, for example, a write-protect cause for an absent page. Entries that already have the accessed and dirty flags set catch a design that raises the write-back strobe on every allowed access. Faulting writes catch a design that sets the dirty flag or strobes even though the access was denied. The random filler bits catch any change to the spare fields or any mix-up in the address slice.

// File: rtl/pte_gate_pkg.sv
package pte_gate_pkg;
  localparam int ENTRY_W = 64;
  localparam int OFFS_W  = 12;
  localparam int PA_W    = 52;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_WT    = 3;
  localparam int B_CD    = 4;
  localparam int B_ACC   = 5;
  localparam int B_DRT   = 6;
  localparam int B_NX    = ENTRY_W - 1;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_PRIV   = 3'd2,
    CAUSE_RDONLY = 3'd3,
    CAUSE_NOEXEC = 3'd4
  } cause_e;
endpackage

// File: rtl/pte_fault_eval.sv
module pte_fault_eval
  import pte_gate_pkg::*;
#(
  parameter int EW = ENTRY_W
) (
  input  logic [EW-1:0] entry,
  input  logic [1:0]    kind,
  input  logic          user,
  output logic          fault,
  output logic [2:0]    cause
);
  cause_e c;

  // Fixed priority: absent, privilege, read-only, no-execute.
  always_comb begin
    c = CAUSE_NONE;
    if (!entry[B_PRES])                                 c = CAUSE_ABSENT;
    else if (user && !entry[B_USR])                     c = CAUSE_PRIV;
    else if (kind == ACC_WRITE && !entry[B_WR])         c = CAUSE_RDONLY;
    else if (kind == ACC_FETCH && entry[EW-1])          c = CAUSE_NOEXEC;
  end

  assign cause = c;
  assign fault = (c != CAUSE_NONE);
endmodule

// File: rtl/pte_flag_update.sv
module pte_flag_update
  import pte_gate_pkg::*;
#(
  parameter int EW = ENTRY_W
) (
  input  logic [EW-1:0] entry,
  input  logic [1:0]    kind,
  output logic [EW-1:0] upd_entry,
  output logic          changed
);
  always_comb begin
    upd_entry        = entry;
    upd_entry[B_ACC] = 1'b1;
    if (kind == ACC_WRITE) upd_entry[B_DRT] = 1'b1;
  end

  assign changed = (upd_entry != entry);
endmodule

// File: rtl/pte_access_gate.sv
module pte_access_gate
  import pte_gate_pkg::*;
#(
  parameter int EW  = ENTRY_W,
  parameter int OW  = OFFS_W,
  parameter int AW  = PA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [EW-1:0] req_entry,
  input  logic [1:0]    req_kind,
  input  logic          req_user,
  input  logic [OW-1:0] req_offset,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [2:0]    rsp_cause,
  output logic [EW-1:0] rsp_entry,
  output logic          rsp_wb,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_wt,
  output logic          rsp_nocache
);
  localparam int PPN_W = AW - OW;

  logic          flt;
  logic [2:0]    cse;
  logic [EW-1:0] upd;
  logic          chg;
  logic [AW-1:0] pa_next;

  pte_fault_eval #(.EW(EW)) u_fault (
    .entry (req_entry),
    .kind  (req_kind),
    .user  (req_user),
    .fault (flt),
    .cause (cse)
  );

  pte_flag_update #(.EW(EW)) u_upd (
    .entry     (req_entry),
    .kind      (req_kind),
    .upd_entry (upd),
    .changed   (chg)
  );

  assign pa_next = {req_entry[OW +: PPN_W], req_offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_cause   <= '0;
      rsp_entry   <= '0;
      rsp_wb      <= 1'b0;
      rsp_paddr   <= '0;
      rsp_wt      <= 1'b0;
      rsp_nocache <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_wb    <= req_valid & ~flt & chg;
      if (req_valid) begin
        rsp_fault   <= flt;
        rsp_cause   <= cse;
        rsp_entry   <= flt ? req_entry : upd;
        rsp_paddr   <= pa_next;
        rsp_wt      <= req_entry[B_WT];
        rsp_nocache <= req_entry[B_CD];
      end
    end
  end
endmodule

// File: rtl/pte_access_gate_chk.sv
module pte_access_gate_chk
  import pte_gate_pkg::*;
#(
  parameter int EW = ENTRY_W,
  parameter int OW = OFFS_W,
  parameter int AW = PA_W
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [EW-1:0] req_entry,
  input logic [1:0]    req_kind,
  input logic          req_user,
  input logic [OW-1:0] req_offset,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [2:0]    rsp_cause,
  input logic [EW-1:0] rsp_entry,
  input logic          rsp_wb,
  input logic [AW-1:0] rsp_paddr
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_absent_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_entry[B_PRES]) |=> (rsp_fault && rsp_cause == 3'd1));
  assert_priv_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_entry[B_PRES] && req_user && !req_entry[B_USR])
      |=> (rsp_fault && rsp_cause == 3'd2));
  assert_noexec_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_entry[B_PRES] && (!req_user || req_entry[B_USR])
      && req_kind == 2'd2 && req_entry[EW-1]) |=> (rsp_cause == 3'd4));
  assert_fault_nowb_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !rsp_wb);
  assert_fault_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_entry[B_PRES]) |=> (rsp_entry == $past(req_entry)));
  assert_accessed_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_entry[B_ACC]);
  assert_wb_change_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid ##1 (rsp_valid && !rsp_fault))
      |-> (rsp_wb == (rsp_entry != $past(req_entry))));
  assert_paddr_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_paddr == {$past(req_entry[AW-1:OW]), $past(req_offset)}));
endmodule

bind pte_access_gate pte_access_gate_chk #(.EW(EW), .OW(OW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_entry  (req_entry),
  .req_kind   (req_kind),
  .req_user   (req_user),
  .req_offset (req_offset),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_cause  (rsp_cause),
  .rsp_entry  (rsp_entry),
  .rsp_wb     (rsp_wb),
  .rsp_paddr  (rsp_paddr)
);

// File: tb/pte_access_gate_bench.sv
module pte_access_gate_bench;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [63:0]   req_entry = '0;
  logic [1:0]    req_kind = '0;
  logic          req_user = 1'b0;
  logic [11:0]   req_offset = '0;
  logic          rsp_valid, rsp_fault, rsp_wb, rsp_wt, rsp_nocache;
  logic [2:0]    rsp_cause;
  logic [63:0]   rsp_entry;
  logic [51:0]   rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pte_access_gate u_pte_access_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_entry(req_entry),
    .req_kind(req_kind), .req_user(req_user), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_entry(rsp_entry), .rsp_wb(rsp_wb), .rsp_paddr(rsp_paddr),
    .rsp_wt(rsp_wt), .rsp_nocache(rsp_nocache)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [63:0] e, input logic [1:0] k,
                         input logic u, input logic [11:0] off);
    logic [2:0]  ec;
    logic [63:0] ee;
    logic        ewb;
    string       ctag;
    // Expected cause from the priority order.
    if (!e[0])                    begin ec = 3'd1; ctag = "R3"; end
    else if (u && !e[2])          begin ec = 3'd2; ctag = "R4"; end
    else if (k == 2'd1 && !e[1])  begin ec = 3'd3; ctag = "R5"; end
    else if (k == 2'd2 && e[63])  begin ec = 3'd4; ctag = "R6"; end
    else                          begin ec = 3'd0; ctag = "R7"; end
    ee = e;
    if (ec == 3'd0) begin
      ee[5] = 1'b1;
      if (k == 2'd1) ee[6] = 1'b1;
    end
    ewb = (ec == 3'd0) && (ee != e);
    @(negedge clk);
    req_valid = 1'b1; req_entry = e; req_kind = k; req_user = u; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 valid", {63'd0, rsp_valid}, 64'd1);
    check(ctag, {61'd0, rsp_cause}, {61'd0, ec});
    check("R7 fault", {63'd0, rsp_fault}, {63'd0, ec != 3'd0});
    check("R8 R11 entry", rsp_entry, ee);
    check("R9 wb", {63'd0, rsp_wb}, {63'd0, ewb});
    check("R10 paddr", {12'd0, rsp_paddr}, {12'd0, e[51:12], off});
    check("R11 cache", {62'd0, rsp_nocache, rsp_wt}, {62'd0, e[4], e[3]});
    @(negedge clk);
    check("R2 idle", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    logic [63:0] seed;
    logic [63:0] e;
    seed = 64'h9E37_79B9_7F4A_7C15;
    // Reset with a request present: outputs must stay zero.
    req_valid = 1'b1; req_entry = '1; req_kind = 2'd1; req_user = 1'b1; req_offset = '1;
    repeat (3) @(negedge clk);
    check("R1 valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 entry", rsp_entry, 64'd0);
    check("R1 paddr", {12'd0, rsp_paddr}, 64'd0);
    check("R1 misc", {58'd0, rsp_fault, rsp_cause, rsp_wb, rsp_wt | rsp_nocache}, 64'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R2 no request", {63'd0, rsp_valid}, 64'd0);
    // Sweep checked flags x kinds x modes; other bits pseudo-random (R11).
    for (int s = 0; s < 64; s++) begin
      for (int k = 0; k < 4; k++) begin
        for (int u = 0; u < 2; u++) begin
          seed = seed ^ (seed << 13);
          seed = seed ^ (seed >> 7);
          seed = seed ^ (seed << 17);
          e = seed & ~64'h8000_0000_0000_0067;
          e[0] = s[0]; e[1] = s[1]; e[2] = s[2];
          e[5] = s[3]; e[6] = s[4]; e[63] = s[5];
          run_req(e, k[1:0], u[0], seed[43:32]);
        end
      end
    end
    // Filler bits set to all ones with a clean writable user page (R11, R8).
    run_req(64'h7FFF_FFFF_FFFF_FF9F, 2'd1, 1'b1, 12'hABC);
    run_req(64'h0000_0000_0000_0007, 2'd2, 1'b0, 12'h000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule